// File: doc/BRIEF.md
# PCIe Root Port Bring-Up Sequencer

This block orders the power-up of a PCIe root port. A start pulse walks it through a fixed chain of states. First the power-down reset is released, then the soft reset. Next the root-complex mode bit is set, followed by a timed wait, and link training is explicitly held off. PHY initialisation is then requested and awaited, followed by a request for address-window and inbound-region setup. A board-level PERST# pulse of timed length follows, with a timed settle after it. Link training is enabled only after all of this, and at that point the port reports ready and opens configuration access.

States, in order: `ST_IDLE`, `ST_PWR_UP`, `ST_SOFT_UP`, `ST_DEV_SET`, `ST_DEV_WAIT`, `ST_TRAIN_OFF`, `ST_PHY_INIT`, `ST_WIN_SETUP`, `ST_PERST_LOW`, `ST_PERST_SETTLE`, `ST_LINK_ON`, plus `ST_FAULT`. The transitions are:
- idle→power-up on start.
- One-cycle steps through `ST_PWR_UP`, `ST_SOFT_UP`, `ST_DEV_SET` and `ST_TRAIN_OFF`.
- Timed exits from `ST_DEV_WAIT`, `ST_PERST_LOW` and `ST_PERST_SETTLE`.
- PHY-init→window-setup on PHY done.
- PHY-init→fault on timeout.
- Window-setup→PERST-low on setup done.
- Any active state→idle on suspend.

`ST_FAULT` is left only through reset. A resume is simply a new start after a suspend, and it reruns the whole chain. All delays are counted in milliseconds by a prescaled timer that restarts on every state change. A state timed for N ms therefore lasts N×`TICKS_PER_MS`+1 cycles.

Top module: `rp_bringup_seq`

## Requirements
- R1: After reset every output is idle: both reset releases low, `ctrl_word_o` all zero, `perst_n_o` high, no request, and `phy_ok_o`, `link_ready_o`, `cfg_allowed_o`, `fault_o` low.
- R2: A start in idle raises `pd_release_o` in the next cycle. `srst_release_o` rises one cycle later. Root-complex mode, bit 0 of `ctrl_word_o`, rises one cycle after that.
- R3: `phy_init_req_o` rises exactly DEV_WAIT_MS×TICKS_PER_MS+3 cycles after bit 0 of `ctrl_word_o`, and training enable (bit 2 of `ctrl_word_o`) is low when it rises.
- R4: `phy_init_req_o` stays high until `phy_done_i` is sampled. In the next cycle `phy_init_req_o` is low while `setup_req_o` and `phy_ok_o` are high.
- R5: `setup_req_o` stays high until `setup_done_i` is sampled, and in the next cycle `perst_n_o` goes low.
- R6: `perst_n_o` stays low for exactly PERST_LOW_MS×TICKS_PER_MS+1 cycles and then returns high.
- R7: After PERST# returns high, `cfg_allowed_o`, `link_ready_o` and training enable stay low for exactly SETTLE_MS×TICKS_PER_MS+1 cycles. They then rise together, giving `ctrl_word_o` = 8'h05.
- R8: If `phy_done_i` has not been sampled by cycle PHY_TMO_MS×TICKS_PER_MS of PHY initialisation (cycles counted from 0), `fault_o` rises in the next cycle and all controls drop. A `phy_done_i` in that same last cycle counts as success.
- R9: The fault state ignores start, suspend and PHY done, and only reset clears it.
- R10: Suspend in any active state returns all outputs, `phy_ok_o` included, to their idle values in the next cycle. A later start reruns the sequence from the power-down release.
- R11: Start is ignored while a sequence is under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the bring-up sequence (idle only) |
| suspend_i | input | 1 | Abort to idle and forget PHY state |
| phy_done_i | input | 1 | PHY initialisation finished |
| setup_done_i | input | 1 | Window and region setup finished |
| ctrl_word_o | output | CTRL_W | Control word: bit 0 root-complex mode, bit 2 training enable |
| pd_release_o | output | 1 | Power-down reset released |
| srst_release_o | output | 1 | Soft reset released |
| perst_n_o | output | 1 | Board-level PERST#, active low |
| phy_init_req_o | output | 1 | Request PHY initialisation |
| setup_req_o | output | 1 | Request window and region setup |
| phy_ok_o | output | 1 | PHY initialisation seen complete |
| link_ready_o | output | 1 | Training enabled, port ready |
| cfg_allowed_o | output | 1 | Configuration accesses permitted |
| fault_o | output | 1 | PHY timeout fault, sticky until reset |

## Verification
Two events can land in the same cycle: the PHY-done handshake and the expiry of the PHY timeout. The bench raises `phy_done_i` exactly in cycle PHY_TMO_MS×TICKS_PER_MS of PHY initialisation. It then judges that the next cycle shows `setup_req_o` and `phy_ok_o` high with `fault_o` low. Neighbouring latencies, one cycle earlier and well past the limit, confirm that the boundary falls on that cycle and on no other.

// File: rtl/rp_seq_pkg.sv
package rp_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR_UP,
        ST_SOFT_UP,
        ST_DEV_SET,
        ST_DEV_WAIT,
        ST_TRAIN_OFF,
        ST_PHY_INIT,
        ST_WIN_SETUP,
        ST_PERST_LOW,
        ST_PERST_SETTLE,
        ST_LINK_ON,
        ST_FAULT
    } seq_state_e;

    // Bit positions decoded by the neighbouring controller
    localparam int unsigned CTRL_BIT_RC    = 0;
    localparam int unsigned CTRL_BIT_TRAIN = 2;

    typedef struct packed {
        logic pd_rel;
        logic srst_rel;
        logic rc_mode;
        logic train_en;
        logic perst_n;
        logic phy_req;
        logic setup_req;
        logic ready;
        logic cfg_ok;
        logic fault;
    } seq_ctrl_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rp_ms_timer.sv
module rp_ms_timer #(
    parameter int unsigned TICKS_PER_MS = 50000,
    parameter int unsigned MS_W         = 7
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            clr_i,
    output logic [MS_W-1:0] ms_o
);
    localparam int unsigned      PRE_W    = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);
    localparam logic [MS_W-1:0]  MS_MAX   = '1;

    logic [PRE_W-1:0] pre_q;
    logic [MS_W-1:0]  ms_q;
    logic             tick;

    assign tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (clr_i) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (tick) begin
            pre_q <= '0;
            if (ms_q != MS_MAX) begin
                ms_q <= ms_q + 1'b1;
            end
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign ms_o = ms_q;

endmodule

// File: rtl/rp_seq_fsm.sv
module rp_seq_fsm
    import rp_seq_pkg::*;
#(
    parameter int unsigned DEV_WAIT_MS  = 1,
    parameter int unsigned PHY_TMO_MS   = 10,
    parameter int unsigned PERST_LOW_MS = 2,
    parameter int unsigned SETTLE_MS    = 100,
    parameter int unsigned MS_W         = 7
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic            suspend_i,
    input  logic            phy_done_i,
    input  logic            setup_done_i,
    input  logic [MS_W-1:0] ms_i,
    output seq_state_e      state_o,
    output logic            tmr_clr_o,
    output logic            phy_ok_o
);
    seq_state_e st_q, st_d;
    logic       phy_ok_q;
    logic       dev_wait_done, phy_tmo, perst_done, settle_done, active;

    assign dev_wait_done = (ms_i >= MS_W'(DEV_WAIT_MS));
    assign phy_tmo       = (ms_i >= MS_W'(PHY_TMO_MS));
    assign perst_done    = (ms_i >= MS_W'(PERST_LOW_MS));
    assign settle_done   = (ms_i >= MS_W'(SETTLE_MS));
    assign active        = (st_q != ST_IDLE) && (st_q != ST_FAULT);

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (active && suspend_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:         if (start_i) st_d = ST_PWR_UP;
                ST_PWR_UP:       st_d = ST_SOFT_UP;
                ST_SOFT_UP:      st_d = ST_DEV_SET;
                ST_DEV_SET:      st_d = ST_DEV_WAIT;
                ST_DEV_WAIT:     if (dev_wait_done) st_d = ST_TRAIN_OFF;
                ST_TRAIN_OFF:    st_d = ST_PHY_INIT;
                ST_PHY_INIT: begin
                    if (phy_done_i)   st_d = ST_WIN_SETUP;
                    else if (phy_tmo) st_d = ST_FAULT;
                end
                ST_WIN_SETUP:    if (setup_done_i) st_d = ST_PERST_LOW;
                ST_PERST_LOW:    if (perst_done) st_d = ST_PERST_SETTLE;
                ST_PERST_SETTLE: if (settle_done) st_d = ST_LINK_ON;
                ST_LINK_ON:      st_d = ST_LINK_ON;
                ST_FAULT:        st_d = ST_FAULT;
                default:         st_d = ST_IDLE;
            endcase
        end
    end

    // PHY-ready memory: set on the handshake, lost on idle or fault
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phy_ok_q <= 1'b0;
        end else if (st_d == ST_IDLE || st_d == ST_FAULT) begin
            phy_ok_q <= 1'b0;
        end else if (st_q == ST_PHY_INIT && st_d == ST_WIN_SETUP) begin
            phy_ok_q <= 1'b1;
        end
    end

    assign tmr_clr_o = (st_d != st_q);
    assign state_o   = st_q;
    assign phy_ok_o  = phy_ok_q;

    AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_DEV_WAIT && start_i && !suspend_i && !dev_wait_done) |=> (st_q == ST_DEV_WAIT)); // R11

    AST_FAULT_EXIT_ONLY_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_FAULT) |=> (st_q == ST_FAULT)); // R9

endmodule

// File: rtl/rp_ctrl_decode.sv
module rp_ctrl_decode
    import rp_seq_pkg::*;
(
    input  seq_state_e state_i,
    output seq_ctrl_t  ctrl_o
);
    always_comb begin
        ctrl_o         = '0;
        ctrl_o.perst_n = 1'b1;
        unique case (state_i)
            ST_IDLE: ;
            ST_PWR_UP: begin
                ctrl_o.pd_rel = 1'b1;
            end
            ST_SOFT_UP: begin
                ctrl_o.pd_rel   = 1'b1;
                ctrl_o.srst_rel = 1'b1;
            end
            ST_DEV_SET, ST_DEV_WAIT, ST_TRAIN_OFF: begin
                ctrl_o.pd_rel   = 1'b1;
                ctrl_o.srst_rel = 1'b1;
                ctrl_o.rc_mode  = 1'b1;
            end
            ST_PHY_INIT: begin
                ctrl_o.pd_rel   = 1'b1;
                ctrl_o.srst_rel = 1'b1;
                ctrl_o.rc_mode  = 1'b1;
                ctrl_o.phy_req  = 1'b1;
            end
            ST_WIN_SETUP: begin
                ctrl_o.pd_rel    = 1'b1;
                ctrl_o.srst_rel  = 1'b1;
                ctrl_o.rc_mode   = 1'b1;
                ctrl_o.setup_req = 1'b1;
            end
            ST_PERST_LOW: begin
                ctrl_o.pd_rel   = 1'b1;
                ctrl_o.srst_rel = 1'b1;
                ctrl_o.rc_mode  = 1'b1;
                ctrl_o.perst_n  = 1'b0;
            end
            ST_PERST_SETTLE: begin
                ctrl_o.pd_rel   = 1'b1;
                ctrl_o.srst_rel = 1'b1;
                ctrl_o.rc_mode  = 1'b1;
            end
            ST_LINK_ON: begin
                ctrl_o.pd_rel   = 1'b1;
                ctrl_o.srst_rel = 1'b1;
                ctrl_o.rc_mode  = 1'b1;
                ctrl_o.train_en = 1'b1;
                ctrl_o.ready    = 1'b1;
                ctrl_o.cfg_ok   = 1'b1;
            end
            ST_FAULT: begin
                ctrl_o.fault = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rp_bringup_seq.sv
module rp_bringup_seq
    import rp_seq_pkg::*;
#(
    parameter int unsigned TICKS_PER_MS = 50000,
    parameter int unsigned DEV_WAIT_MS  = 1,
    parameter int unsigned PHY_TMO_MS   = 10,
    parameter int unsigned PERST_LOW_MS = 2,
    parameter int unsigned SETTLE_MS    = 100,
    parameter int unsigned CTRL_W       = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              suspend_i,
    input  logic              phy_done_i,
    input  logic              setup_done_i,
    output logic [CTRL_W-1:0] ctrl_word_o,
    output logic              pd_release_o,
    output logic              srst_release_o,
    output logic              perst_n_o,
    output logic              phy_init_req_o,
    output logic              setup_req_o,
    output logic              phy_ok_o,
    output logic              link_ready_o,
    output logic              cfg_allowed_o,
    output logic              fault_o
);
    localparam int unsigned MAX_MS = max_u(max_u(DEV_WAIT_MS, PHY_TMO_MS),
                                           max_u(PERST_LOW_MS, SETTLE_MS));
    localparam int unsigned MS_W   = $clog2(MAX_MS + 2);

    seq_state_e      state;
    seq_ctrl_t       ctl;
    logic            tmr_clr;
    logic [MS_W-1:0] ms_cnt;

    rp_ms_timer #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .MS_W         (MS_W)
    ) i_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (tmr_clr),
        .ms_o   (ms_cnt)
    );

    rp_seq_fsm #(
        .DEV_WAIT_MS  (DEV_WAIT_MS),
        .PHY_TMO_MS   (PHY_TMO_MS),
        .PERST_LOW_MS (PERST_LOW_MS),
        .SETTLE_MS    (SETTLE_MS),
        .MS_W         (MS_W)
    ) i_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .suspend_i    (suspend_i),
        .phy_done_i   (phy_done_i),
        .setup_done_i (setup_done_i),
        .ms_i         (ms_cnt),
        .state_o      (state),
        .tmr_clr_o    (tmr_clr),
        .phy_ok_o     (phy_ok_o)
    );

    rp_ctrl_decode i_decode (
        .state_i (state),
        .ctrl_o  (ctl)
    );

    for (genvar b = 0; b < CTRL_W; b++) begin : g_ctrl
        if (b == CTRL_BIT_RC) begin : g_rc
            assign ctrl_word_o[b] = ctl.rc_mode;
        end else if (b == CTRL_BIT_TRAIN) begin : g_train
            assign ctrl_word_o[b] = ctl.train_en;
        end else begin : g_zero
            assign ctrl_word_o[b] = 1'b0;
        end
    end

    assign pd_release_o   = ctl.pd_rel;
    assign srst_release_o = ctl.srst_rel;
    assign perst_n_o      = ctl.perst_n;
    assign phy_init_req_o = ctl.phy_req;
    assign setup_req_o    = ctl.setup_req;
    assign link_ready_o   = ctl.ready;
    assign cfg_allowed_o  = ctl.cfg_ok;
    assign fault_o        = ctl.fault;

    AST_SOFT_AFTER_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst_release_o |-> pd_release_o); // R2

    AST_PHY_HANDSHAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phy_init_req_o && phy_done_i && !suspend_i) |=> (setup_req_o && phy_ok_o && !phy_init_req_o)); // R4

    AST_PERST_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(perst_n_o) |-> $past(setup_req_o && setup_done_i)); // R5

    AST_TRAIN_NEEDS_PHY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_word_o[CTRL_BIT_TRAIN] |-> (phy_ok_o && perst_n_o)); // R7

    AST_CFG_WITH_TRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_allowed_o |-> (ctrl_word_o[CTRL_BIT_TRAIN] && link_ready_o)); // R7

    AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |=> fault_o); // R9

    AST_SUSPEND_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (suspend_i && pd_release_o) |=> (!pd_release_o && !phy_ok_o && !link_ready_o)); // R10

endmodule

// File: tb/test_rp_bringup_seq.sv
`timescale 1ns/1ps
module test_rp_bringup_seq;
    localparam int TPM    = 10;
    localparam int DEV_MS = 1;
    localparam int TMO_MS = 10;
    localparam int LOW_MS = 2;
    localparam int SET_MS = 100;

    typedef struct packed {
        logic [15:0] phy_lat;
        logic [15:0] setup_lat;
        logic        exp_fault;
    } vec_t;

    // phy latency 100 = same cycle as the timeout expiry (R8)
    localparam vec_t VEC [0:4] = '{
        '{16'd0,   16'd0,  1'b0},
        '{16'd5,   16'd3,  1'b0},
        '{16'd99,  16'd17, 1'b0},
        '{16'd100, 16'd1,  1'b0},
        '{16'd200, 16'd0,  1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, suspend = 1'b0, phy_done = 1'b0, setup_done = 1'b0;
    logic [7:0] ctrl;
    logic       pd_rel, srst_rel, perst_n, phy_req, setup_req, phy_ok, ready, cfg_ok, fault;
    int         n_run = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;

    rp_bringup_seq #(
        .TICKS_PER_MS (TPM),
        .DEV_WAIT_MS  (DEV_MS),
        .PHY_TMO_MS   (TMO_MS),
        .PERST_LOW_MS (LOW_MS),
        .SETTLE_MS    (SET_MS),
        .CTRL_W       (8)
    ) i_rp_bringup_seq (
        .clk_i (clk), .rst_ni (rst_n), .start_i (start), .suspend_i (suspend),
        .phy_done_i (phy_done), .setup_done_i (setup_done), .ctrl_word_o (ctrl),
        .pd_release_o (pd_rel), .srst_release_o (srst_rel), .perst_n_o (perst_n),
        .phy_init_req_o (phy_req), .setup_req_o (setup_req), .phy_ok_o (phy_ok),
        .link_ready_o (ready), .cfg_allowed_o (cfg_ok), .fault_o (fault)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 0; suspend = 0; phy_done = 0; setup_done = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_idle(input string tag);
        chk({tag, " ctrl"}, int'(ctrl), 0);
        chk({tag, " pd/srst"}, int'({pd_rel, srst_rel}), 0);
        chk({tag, " perst_n"}, int'(perst_n), 1);
        chk({tag, " req"}, int'({phy_req, setup_req}), 0);
        chk({tag, " ok/ready/cfg"}, int'({phy_ok, ready, cfg_ok}), 0);
    endtask

    // Returns cycles spent with phy_req high
    task automatic serve_phy(input int lat, output int c);
        c = 0;
        while (phy_req && c <= 400) begin
            phy_done = (c == lat);
            @(negedge clk);
            c++;
        end
        phy_done = 1'b0;
    endtask

    task automatic serve_setup(input int lat, output int c);
        c = 0;
        while (setup_req && c <= 400) begin
            setup_done = (c == lat);
            @(negedge clk);
            c++;
        end
        setup_done = 1'b0;
    endtask

    task automatic wait_phy_req(output int n);
        n = 0;
        while (!phy_req && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_seq(input int lat, input int slat, input bit exp_fault);
        int n, c, bad;
        do_reset();
        pulse_start();
        chk("R2 pd release first", int'({pd_rel, srst_rel}), 2);
        @(negedge clk);
        chk("R2 soft release second", int'({srst_rel, ctrl[0]}), 2);
        @(negedge clk);
        chk("R2 rc mode bit0", int'(ctrl[0]), 1);
        wait_phy_req(n);
        chk("R3 rc-to-phy-req cycles", n, DEV_MS * TPM + 3);
        chk("R3 training off at phy req", int'(ctrl[2]), 0);
        serve_phy(lat, c);
        if (exp_fault) begin
            chk("R8 timeout cycles", c, TMO_MS * TPM + 1);
            chk("R8 fault raised", int'(fault), 1);
            chk("R8 controls dropped", int'({pd_rel, srst_rel, ctrl[0], setup_req}), 0);
            return;
        end
        chk("R4 phy req held", c, lat + 1);
        chk("R4 setup req + phy ok", int'({setup_req, phy_ok, phy_req}), 6);
        chk("R8 no fault on success", int'(fault), 0);
        serve_setup(slat, c);
        chk("R5 setup req held", c, slat + 1);
        chk("R5 perst low after setup", int'(perst_n), 0);
        n = 0;
        while (!perst_n && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk("R6 perst low width", n, LOW_MS * TPM + 1);
        n = 0; bad = 0;
        while (!ready && n < 5000) begin
            if (cfg_ok || ctrl[2]) bad++;
            @(negedge clk);
            n++;
        end
        chk("R7 settle width", n, SET_MS * TPM + 1);
        chk("R7 nothing early in settle", bad, 0);
        chk("R7 final ctrl word", int'(ctrl), 5);
        chk("R7 cfg allowed", int'(cfg_ok), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int n, c;
        do_reset();
        check_idle("R1 reset");
        chk("R1 fault", int'(fault), 0);

        for (int i = 0; i < 5; i++) begin
            run_seq(int'(VEC[i].phy_lat), int'(VEC[i].setup_lat), VEC[i].exp_fault);
        end

        // R9: fault ignores start, suspend and phy done until reset
        start = 1; suspend = 1; phy_done = 1;
        @(negedge clk);
        start = 0; suspend = 0; phy_done = 0;
        @(negedge clk);
        chk("R9 fault held", int'(fault), 1);
        chk("R9 nothing released", int'({pd_rel, phy_req, setup_req}), 0);
        do_reset();
        chk("R9 reset clears fault", int'(fault), 0);

        // R11: start mid-sequence
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_start();
        chk("R11 no restart", int'({pd_rel, srst_rel, ctrl[0]}), 7);
        wait_phy_req(n);
        chk("R11 phy req still reached", int'(phy_req), 1);

        // R10: suspend during settle, then resume
        serve_phy(2, c);
        serve_setup(2, c);
        while (!perst_n) @(negedge clk);
        repeat (4) @(negedge clk);
        suspend = 1'b1;
        @(negedge clk);
        suspend = 1'b0;
        check_idle("R10 suspend in settle");
        pulse_start();
        chk("R10 resume pd first", int'({pd_rel, srst_rel}), 2);
        wait_phy_req(n);
        chk("R10 rerun reaches phy init", n, DEV_MS * TPM + 5);

        // R10: suspend after link up
        run_seq(1, 1, 1'b0);
        suspend = 1'b1;
        @(negedge clk);
        suspend = 1'b0;
        check_idle("R10 suspend at link up");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule